// File: doc/BRIEF.md
# Job Transfer Sequencer with Control Registers

This block is the control front end of a compute accelerator. A host processor programs a small bank of 32-bit registers through a simple register write/read port. It sets a base address for fetching operands and a base address for storing results, then issues a start command. The sequencer fetches a fixed number of 1024-bit operand beats from memory and places each one in an operand slot. It then pulses a start strobe to the arithmetic engine and waits for the engine to report completion. After that it stores a fixed number of 1024-bit result beats back to memory. When the last store is acknowledged, it raises a done flag that software polls.

The memory side uses a request/acknowledge port. Each transfer is a one-cycle request, and only one transfer is outstanding at a time. Successive beats sit 128 bytes apart, because every data item in memory is 128-byte aligned. The arithmetic engine reads the operands through an index/data port. It supplies each result beat on a data input selected by the result index that the sequencer drives.

Top module: `xseq_top`

## Requirements
- R1: The register bank has eight 32-bit word-indexed registers. Index 2 holds the fetch base address, index 3 holds the store base address, and indices 4 to 7 are general read/write storage. A value written to any of these reads back unchanged.
- R2: Index 0 is the command register. Writing exactly the value 1 starts a job when the block is neither busy nor done. The written value reads back for one cycle only, then the register reads 0. Any other value starts nothing.
- R3: Index 1 is the status register, with bit 0 for busy, bit 1 for done, and all other bits reading 0. Busy is set from the cycle after the command is accepted until the last store is acknowledged. Done is set at that point. Busy and done are never set together.
- R4: A job first issues 13 fetch requests, each one cycle long with mem_we low. Fetch k (k = 0 to 12, in order) goes to fetch base + 128*k. A request is issued only after the previous one has been acknowledged.
- R5: The data acknowledged for fetch k is stored in operand slot k and can be read back on opnd_data by driving opnd_idx = k.
- R6: After the 13th fetch acknowledge, cmp_start pulses high for exactly one cycle, once per job. No memory request is issued until cmp_done is seen after that pulse.
- R7: The block then issues 15 store requests with mem_we high. Store k (k = 0 to 14) goes to store base + 128*k. Its mem_wdata equals res_data while res_idx = k. Done rises in the cycle after the 15th store acknowledge, after exactly 28 requests in the job.
- R8: Any write to the status register clears done. A start command written while busy, or while done is still set, is dropped and never starts a job.
- R9: Transfer addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_waddr | input | 3 | Register write index |
| csr_wdata | input | 32 | Register write data |
| csr_raddr | input | 3 | Register read index |
| csr_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | One-cycle memory transfer request |
| mem_we | output | 1 | High for a store, low for a fetch |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | 1024 | Store data |
| mem_ack | input | 1 | Transfer acknowledge; carries fetch data |
| mem_rdata | input | 1024 | Fetch data, valid with mem_ack |
| cmp_start | output | 1 | One-cycle engine start strobe |
| cmp_done | input | 1 | Engine completion strobe |
| opnd_idx | input | 4 | Operand slot select |
| opnd_data | output | 1024 | Selected operand slot |
| res_idx | output | 4 | Result beat being stored |
| res_data | input | 1024 | Result beat from the engine |

## Verification
Jobs are swept over acknowledge latencies of one to three cycles, two engine run times, and two base-address pairs. One pair sits in the middle of the address space and the other lies near the top, so both fetch and store addresses wrap past zero. Every request address, every store beat and every operand slot is compared against values derived from the base registers and the index arithmetic. Across the sweep this separates an off-by-one in the counters, a stride error, a lost wrap and a phase ordering fault. Separate patterns cover a non-1 command value, a command written mid-job, and a command written while done is still set. Each of these must leave the memory port silent, while a status write must clear done.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_REQ,
        ST_RX_WAIT,
        ST_COMPUTE,
        ST_TX_REQ,
        ST_TX_WAIT,
        ST_DONE
    } seq_state_e;

    // Register indices whose position the host software depends on
    localparam int REG_CMD  = 0;
    localparam int REG_STAT = 1;
    localparam int REG_RXB  = 2;
    localparam int REG_TXB  = 3;

    // Status bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;

endpackage

// File: rtl/xseq_csr.sv
module xseq_csr
    import xseq_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int N_REGS = 8,
    localparam int IDX_W   = $clog2(N_REGS),
    localparam int N_SPARE = N_REGS - 4,
    localparam int SP_W    = $clog2(N_SPARE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [REG_W-1:0] rdata,
    input  logic             job_end,
    output logic             start_req,
    output logic [REG_W-1:0] rx_base,
    output logic [REG_W-1:0] tx_base,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic [REG_W-1:0]                cmd;
        logic                            busy;
        logic                            done;
        logic [REG_W-1:0]                rxb;
        logic [REG_W-1:0]                txb;
        logic [N_SPARE-1:0][REG_W-1:0]   spare;
    } csr_t;

    csr_t q, d;

    // A pending command of exactly 1 is accepted only from a clean idle state
    assign start_req = (q.cmd == REG_W'(1)) && !q.busy && !q.done;

    always_comb begin
        d     = q;
        d.cmd = '0;
        if (start_req) begin
            d.busy = 1'b1;
        end
        if (we) begin
            case (waddr)
                IDX_W'(REG_CMD):  d.cmd  = wdata;
                IDX_W'(REG_STAT): d.done = 1'b0;
                IDX_W'(REG_RXB):  d.rxb  = wdata;
                IDX_W'(REG_TXB):  d.txb  = wdata;
                default:          d.spare[waddr[SP_W-1:0]] = wdata;
            endcase
        end
        // completion wins over a same-cycle status write
        if (job_end) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (raddr)
            IDX_W'(REG_CMD):  rdata = q.cmd;
            IDX_W'(REG_STAT): begin
                rdata            = '0;
                rdata[STAT_BUSY] = q.busy;
                rdata[STAT_DONE] = q.done;
            end
            IDX_W'(REG_RXB):  rdata = q.rxb;
            IDX_W'(REG_TXB):  rdata = q.txb;
            default:          rdata = q.spare[raddr[SP_W-1:0]];
        endcase
    end

    assign rx_base = q.rxb;
    assign tx_base = q.txb;
    assign busy    = q.busy;
    assign done    = q.done;

endmodule

// File: rtl/xseq_opbank.sv
module xseq_opbank #(
    parameter int N_SLOTS = 13,
    parameter int DATA_W  = 1024,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [N_SLOTS-1:0]             hit;
    logic [N_SLOTS-1:0][DATA_W-1:0] bank_d, bank_q;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            bank_d[i] = hit[i] ? wr_data : bank_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        if (int'(rd_idx) < N_SLOTS) begin
            rd_data = bank_q[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/xseq_fsm.sv
module xseq_fsm
    import xseq_pkg::*;
#(
    parameter int N_RX   = 13,
    parameter int N_TX   = 15,
    parameter int ADDR_W = 32,
    parameter int STRIDE = 128,
    localparam int N_MAX    = (N_RX > N_TX) ? N_RX : N_TX,
    localparam int CNT_W    = $clog2(N_MAX + 1),
    localparam int RX_IDX_W = $clog2(N_RX),
    localparam int TX_IDX_W = $clog2(N_TX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic [ADDR_W-1:0]   rx_base,
    input  logic [ADDR_W-1:0]   tx_base,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    output logic                cap_en,
    output logic [RX_IDX_W-1:0] cap_idx,
    output logic                cmp_start,
    input  logic                cmp_done,
    output logic [TX_IDX_W-1:0] res_idx,
    output logic                job_end
);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             cstart;
    } fsm_t;

    fsm_t q, d;

    logic rx_last, tx_last;

    assign rx_last = (q.cnt == CNT_W'(N_RX - 1));
    assign tx_last = (q.cnt == CNT_W'(N_TX - 1));

    always_comb begin
        d        = q;
        d.cstart = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_req) begin
                    d.state = ST_RX_REQ;
                    d.cnt   = '0;
                end
            end
            ST_RX_REQ: d.state = ST_RX_WAIT;
            ST_RX_WAIT: begin
                if (mem_ack) begin
                    if (rx_last) begin
                        d.state  = ST_COMPUTE;
                        d.cnt    = '0;
                        d.cstart = 1'b1;
                    end else begin
                        d.state = ST_RX_REQ;
                        d.cnt   = q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_COMPUTE: begin
                // completion is not taken in the strobe cycle itself
                if (!q.cstart && cmp_done) begin
                    d.state = ST_TX_REQ;
                end
            end
            ST_TX_REQ: d.state = ST_TX_WAIT;
            ST_TX_WAIT: begin
                if (mem_ack) begin
                    if (tx_last) begin
                        d.state = ST_DONE;
                    end else begin
                        d.state = ST_TX_REQ;
                        d.cnt   = q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, cstart: 1'b0};
        end else begin
            q <= d;
        end
    end

    logic              tx_phase;
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] offset;

    assign tx_phase = (q.state == ST_TX_REQ) || (q.state == ST_TX_WAIT);
    assign base_sel = tx_phase ? tx_base : rx_base;
    assign offset   = ADDR_W'(q.cnt) * ADDR_W'(STRIDE);

    assign mem_req   = (q.state == ST_RX_REQ) || (q.state == ST_TX_REQ);
    assign mem_we    = (q.state == ST_TX_REQ);
    assign mem_addr  = base_sel + offset;
    assign cap_en    = (q.state == ST_RX_WAIT) && mem_ack;
    assign cap_idx   = q.cnt[RX_IDX_W-1:0];
    assign res_idx   = q.cnt[TX_IDX_W-1:0];
    assign cmp_start = q.cstart;
    assign job_end   = (q.state == ST_TX_WAIT) && mem_ack && tx_last;

endmodule

// File: rtl/xseq_top.sv
module xseq_top
    import xseq_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int N_REGS = 8,
    parameter int DATA_W = 1024,
    parameter int N_RX   = 13,
    parameter int N_TX   = 15,
    parameter int STRIDE = 128,
    localparam int CSR_IDX_W = $clog2(N_REGS),
    localparam int RX_IDX_W  = $clog2(N_RX),
    localparam int TX_IDX_W  = $clog2(N_TX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic [CSR_IDX_W-1:0] csr_waddr,
    input  logic [REG_W-1:0]     csr_wdata,
    input  logic [CSR_IDX_W-1:0] csr_raddr,
    output logic [REG_W-1:0]     csr_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [REG_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 cmp_start,
    input  logic                 cmp_done,
    input  logic [RX_IDX_W-1:0]  opnd_idx,
    output logic [DATA_W-1:0]    opnd_data,
    output logic [TX_IDX_W-1:0]  res_idx,
    input  logic [DATA_W-1:0]    res_data
);

    logic                start_req;
    logic                job_end;
    logic                busy_w;
    logic                done_w;
    logic [REG_W-1:0]    rx_base;
    logic [REG_W-1:0]    tx_base;
    logic                cap_en;
    logic [RX_IDX_W-1:0] cap_idx;

    xseq_csr #(
        .REG_W  (REG_W),
        .N_REGS (N_REGS)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (csr_we),
        .waddr     (csr_waddr),
        .wdata     (csr_wdata),
        .raddr     (csr_raddr),
        .rdata     (csr_rdata),
        .job_end   (job_end),
        .start_req (start_req),
        .rx_base   (rx_base),
        .tx_base   (tx_base),
        .busy      (busy_w),
        .done      (done_w)
    );

    xseq_fsm #(
        .N_RX   (N_RX),
        .N_TX   (N_TX),
        .ADDR_W (REG_W),
        .STRIDE (STRIDE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .rx_base   (rx_base),
        .tx_base   (tx_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cmp_start (cmp_start),
        .cmp_done  (cmp_done),
        .res_idx   (res_idx),
        .job_end   (job_end)
    );

    xseq_opbank #(
        .N_SLOTS (N_RX),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_en),
        .wr_idx  (cap_idx),
        .wr_data (mem_rdata),
        .rd_idx  (opnd_idx),
        .rd_data (opnd_data)
    );

    assign mem_wdata = (mem_req && mem_we) ? res_data : '0;

endmodule

// File: rtl/xseq_chk.sv
module xseq_chk #(
    parameter int N_TOTAL = 28
) (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_we,
    input logic mem_ack,
    input logic cmp_start,
    input logic busy,
    input logic done
);

    logic [15:0] req_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            req_cnt <= '0;
        end else if (mem_req) begin
            req_cnt <= req_cnt + 16'd1;
        end
    end

    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we));

    p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_req_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |=> !cmp_start);

    p_no_req_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |-> !mem_req);

    p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_ack));

    p_total_reqs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (req_cnt == 16'(N_TOTAL)));

endmodule

bind xseq_top xseq_chk #(.N_TOTAL(N_RX + N_TX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .cmp_start (cmp_start),
    .busy      (busy_w),
    .done      (done_w)
);

// File: tb/xseq_top_tb.sv
`timescale 1ns/1ps
module xseq_top_tb;

    localparam int NRX = 13;
    localparam int NTX = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [2:0]    csr_waddr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [2:0]    csr_raddr = '0;
    logic [31:0]   csr_rdata;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr;
    logic [1023:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [1023:0] mem_rdata = '0;
    logic          cmp_start;
    logic          cmp_done = 1'b0;
    logic [3:0]    opnd_idx = '0;
    logic [1023:0] opnd_data;
    logic [3:0]    res_idx;
    logic [1023:0] res_data;

    xseq_top u_dut (.*);

    initial forever #2.5 clk = ~clk;

    function automatic logic [1023:0] fetch_pat(input logic [31:0] a);
        return {32{a ^ 32'h5A5A_F00F}};
    endfunction

    function automatic logic [1023:0] res_pat(input int k);
        return {32{32'hC0DE_0000 ^ 32'(k)}};
    endfunction

    assign res_data = res_pat(int'(res_idx));

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    int lat = 1, cdel = 1;
    int n_rd, n_wr, n_cs, order_err, wdata_err;
    bit done_given;
    logic [31:0] rd_log [32];
    logic [31:0] wr_log [32];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_rd = 0; n_wr = 0; n_cs = 0; order_err = 0; wdata_err = 0;
        done_given = 0;
    endtask

    // memory model and request monitor
    initial begin
        int cd;
        logic [1023:0] pend;
        cd = 0;
        pend = '0;
        clear_log();
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_ack = 1'b1;
                    mem_rdata = pend;
                end
            end
            if (mem_req) begin
                if (!mem_we) begin
                    if (n_rd < 32) rd_log[n_rd] = mem_addr;
                    pend = fetch_pat(mem_addr);
                    if (n_cs != 0) order_err++;
                    n_rd++;
                end else begin
                    if (n_wr < 32) wr_log[n_wr] = mem_addr;
                    if (mem_wdata !== res_pat(n_wr)) wdata_err++;
                    if (!done_given) order_err++;
                    n_wr++;
                end
                cd = lat;
            end
        end
    end

    // arithmetic engine model
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_start) begin
                n_cs++;
                if (n_rd != NRX || n_wr != 0) order_err++;
                repeat (cdel) @(negedge clk);
                cmp_done = 1'b1;
                done_given = 1;
                @(negedge clk);
                cmp_done = 1'b0;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = 3'(a); csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        csr_raddr = 3'(a);
        #1;
        v = csr_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd(1, s);
            if (s[1]) break;
        end
    endtask

    task automatic run_job(input logic [31:0] rxb, input logic [31:0] txb,
                           input int l, input int c);
        logic [31:0] v;
        int bad;
        lat = l; cdel = c;
        wr(2, rxb);
        wr(3, txb);
        clear_log();
        wr(0, 32'd1);
        rd(0, v);
        check(v == 32'd1, "R2", "cmd readback after write", 64'(v), 64'd1);
        @(negedge clk);
        rd(0, v);
        check(v == 32'd0, "R2", "cmd self-clear", 64'(v), 64'd0);
        rd(1, v);
        check(v == 32'd1, "R3", "status busy during job", 64'(v), 64'd1);
        wait_done();
        rd(1, v);
        check(v == 32'd2, "R3", "status done after job", 64'(v), 64'd2);
        check(n_rd == NRX, "R4", "fetch count", 64'(n_rd), 64'(NRX));
        bad = 0;
        for (int k = 0; k < NRX; k++)
            if (rd_log[k] !== rxb + 32'(k * 128)) bad++;
        check(bad == 0, "R4 R9", "fetch address mismatches", 64'(bad), 64'd0);
        check(n_cs == 1, "R6", "start strobe count", 64'(n_cs), 64'd1);
        check(order_err == 0, "R6", "phase order errors", 64'(order_err), 64'd0);
        check(n_wr == NTX, "R7", "store count", 64'(n_wr), 64'(NTX));
        bad = 0;
        for (int k = 0; k < NTX; k++)
            if (wr_log[k] !== txb + 32'(k * 128)) bad++;
        check(bad == 0, "R7 R9", "store address mismatches", 64'(bad), 64'd0);
        check(wdata_err == 0, "R7", "store data mismatches", 64'(wdata_err), 64'd0);
        bad = 0;
        for (int k = 0; k < NRX; k++) begin
            opnd_idx = 4'(k);
            #1;
            if (opnd_data !== fetch_pat(rxb + 32'(k * 128))) bad++;
        end
        check(bad == 0, "R5", "operand slot mismatches", 64'(bad), 64'd0);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] bases [4];
        bases[0] = 32'h1000_0000; bases[1] = 32'h2000_0080;
        bases[2] = 32'hFFFF_FC00; bases[3] = 32'hFFFF_FA00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check(v == 32'd0, "R3", "register after reset", 64'(v), 64'd0);
        end
        check(!mem_req && !cmp_start, "R4", "outputs idle after reset",
              64'({mem_req, cmp_start}), 64'd0);

        // register storage
        for (int a = 2; a < 8; a++) wr(a, 32'h1357_0000 + 32'(a * 32'h1111));
        for (int a = 2; a < 8; a++) begin
            rd(a, v);
            check(v == 32'h1357_0000 + 32'(a * 32'h1111), "R1", "register readback",
                  64'(v), 64'(32'h1357_0000 + 32'(a * 32'h1111)));
        end

        // non-1 command value
        clear_log();
        wr(0, 32'd2);
        rd(0, v);
        check(v == 32'd2, "R2", "non-1 cmd readback", 64'(v), 64'd2);
        repeat (20) @(negedge clk);
        rd(1, v);
        check(v == 32'd0 && n_rd == 0, "R2", "non-1 cmd starts nothing",
              64'(n_rd), 64'd0);

        // sweep of latency, engine time and base pairs
        for (int s = 0; s < 2; s++)
            for (int l = 1; l <= 3; l++)
                for (int c = 0; c < 2; c++) begin
                    run_job(bases[2*s], bases[2*s+1], l, (c == 0) ? 1 : 5);
                    wr(1, 32'd0);
                    rd(1, v);
                    check(v == 32'd0, "R8", "status write clears done", 64'(v), 64'd0);
                end

        // command while done is still set
        run_job(32'h0000_4000, 32'h0000_8000, 2, 2);
        clear_log();
        wr(0, 32'd1);
        repeat (30) @(negedge clk);
        rd(1, v);
        check(n_rd == 0 && v == 32'd2, "R8", "cmd ignored while done",
              64'(n_rd), 64'd0);
        wr(1, 32'd0);

        // command while busy
        lat = 2; cdel = 3;
        clear_log();
        wr(0, 32'd1);
        repeat (10) @(negedge clk);
        wr(0, 32'd1);
        wait_done();
        repeat (40) @(negedge clk);
        rd(1, v);
        check(n_rd == NRX && n_wr == NTX && v == 32'd2, "R8",
              "cmd ignored while busy", 64'(n_rd + n_wr), 64'(NRX + NTX));
        wr(1, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule